// File: doc/BRIEF.md
# Static memory bus cycle generator

This block is the host-side master for one chip-select region of an asynchronous static memory bus. An internal requester presents a read or a write together with an address, write data and byte enables, and holds the request until it is acknowledged. The block then plays out one bus cycle on the external pins: an active-low chip select, an active-low read strobe and one active-low write strobe per data byte. The address and write data are held stable for the whole cycle.

The chip select and the strobe each get their own setup delay and pulse width, counted in clocks from the start of the access. The whole access lasts a programmed total length. Whatever part of that length is not covered by the setup and pulse phases is hold time. The lengths are held in four configuration words written through a small write port. Each length field uses a compressed encoding that reaches long cycles with few bits. An external active-low wait input, which may be asynchronous, is passed through two flip-flops. It can then either freeze the access in place or extend the pulse at its end.

Top module: `smc_cycle_engine`

## Requirements
- R1: After reset, cs_n, rd_n and every we_n bit are high, ack and cfg_err are low, and every setup length is 1, every pulse length is 1, both cycle lengths are 3, reads and writes are timed by the chip select, and wait is disabled.
- R2: A 6-bit setup field f gives f when f[5] is 0 and 128 + f[4:0] when f[5] is 1. Setup word (cfg_sel 0) fields: [5:0] read strobe, [11:6] read chip select, [17:12] write strobe, [23:18] write chip select.
- R3: A 7-bit pulse field f gives f when f[6] is 0 and 256 + f[5:0] when f[6] is 1. A 9-bit cycle field c gives 256*c[8:7] + c[6:0]. Pulse word (cfg_sel 1): [6:0] read strobe, [13:7] read chip select, [20:14] write strobe, [27:21] write chip select. Cycle word (cfg_sel 2): [8:0] read, [17:9] write.
- R4: A pulse or cycle field written as zero acts as 1, and the write sets cfg_err, which stays set until reset.
- R5: With the access index counted from 0 in the clock after the request is taken, a signal with setup S and pulse P is low for indices S to S+P-1, cut off at the cycle length C. ack is high for exactly index C, and every strobe and the chip select are high by then.
- R6: The wait input takes effect in the access index two clocks after the clock in which wait_n is first sampled low.
- R7: Mode word (cfg_sel 3) bits [3:2] = 2'b10 selects frozen wait: while the synchronized wait is active, the access makes no progress, the pins hold their levels, and the access lasts one clock longer for each waited clock.
- R8: Bits [3:2] = 2'b11 selects ready wait: only on the last clock of the controlling pulse, if the synchronized wait is active there, that clock repeats until the wait goes inactive. A wait that ends before that clock has no effect.
- R9: With bits [3:2] = 2'b00 (disabled) or 2'b01 (reserved), the wait input has no effect on pin timing or ack.
- R10: Mode bit [0] (reads) and bit [1] (writes) set to 1 make the strobe pulse the controlling pulse, and 0 makes the chip select pulse the controlling pulse. The controlling pulse ends at the smaller of its end and the cycle length.
- R11: A read drives rd_n and never we_n. A write drives we_n[i] only for req_be[i] = 1 and never rd_n, with mem_doe high and mem_dout equal to the request data while a write strobe is low.
- R12: rdata, valid while ack is high, holds mem_din as sampled at the clock edge that closes the last clock of the controlling pulse, after any wait extension. ack lasts one clock, and a request held through ack is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select (0 setup, 1 pulse, 2 cycle, 3 mode) |
| cfg_wdata | input | 28 | Configuration write data |
| cfg_err | output | 1 | Sticky flag for a zero pulse or cycle field |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables for writes |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured read data |
| mem_addr | output | AW | Bus address |
| mem_dout | output | DW | Bus write data |
| mem_doe | output | 1 | Bus data output enable |
| mem_din | input | DW | Bus read data |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| we_n | output | DW/8 | Active-low byte write strobes |
| wait_n | input | 1 | Active-low external wait, may be asynchronous |

## Verification
The two functions that can fall in the same cycle are the ready-mode pulse extension and the read-data capture: a wait that is still active on the last clock of the controlling pulse both repeats that clock and moves the capture edge. The bench provokes this by driving wait_n low a chosen number of clocks into the access, so that its synchronized copy covers, just misses, or ends right at the pulse end. Read data is a free-running clock count, so the captured value gives the exact capture edge. That value, the pin low-counts and the ack index are compared with figures the bench derives from the waited window and the decoded lengths.

// File: rtl/smc_cycle_engine.sv
module smc_cycle_engine #(
  parameter int AW = 23,
  parameter int DW = 16,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [27:0]   cfg_wdata,
  output logic          cfg_err,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NB-1:0] req_be,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_doe,
  input  logic [DW-1:0] mem_din,
  output logic          cs_n,
  output logic          rd_n,
  output logic [NB-1:0] we_n,
  input  logic          wait_n
);

  localparam logic [23:0] SU_RST = 24'h041041;
  localparam logic [27:0] PW_RST = 28'h0204081;
  localparam logic [17:0] CY_RST = 18'h00603;

  function automatic logic [9:0] dec_su(input logic [5:0] f);
    return {2'b00, f[5], 2'b00, f[4:0]};
  endfunction

  function automatic logic [9:0] dec_pw(input logic [6:0] f);
    return (f == 7'd0) ? 10'd1 : {1'b0, f[6], 2'b00, f[5:0]};
  endfunction

  function automatic logic [9:0] dec_cy(input logic [8:0] f);
    return (f == 9'd0) ? 10'd1 : {f[8:7], 1'b0, f[6:0]};
  endfunction

  logic [23:0] su_r;
  logic [27:0] pw_r;
  logic [17:0] cy_r;
  logic [3:0]  md_r;
  logic        zero_pw, zero_cy;

  assign zero_pw = (cfg_wdata[6:0] == 7'd0) || (cfg_wdata[13:7] == 7'd0) ||
                   (cfg_wdata[20:14] == 7'd0) || (cfg_wdata[27:21] == 7'd0);
  assign zero_cy = (cfg_wdata[8:0] == 9'd0) || (cfg_wdata[17:9] == 9'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      su_r    <= SU_RST;
      pw_r    <= PW_RST;
      cy_r    <= CY_RST;
      md_r    <= 4'd0;
      cfg_err <= 1'b0;
    end else if (cfg_wr) begin
      case (cfg_sel)
        2'd0: su_r <= cfg_wdata[23:0];
        2'd1: pw_r <= cfg_wdata;
        2'd2: cy_r <= cfg_wdata[17:0];
        default: md_r <= cfg_wdata[3:0];
      endcase
      if ((cfg_sel == 2'd1 && zero_pw) || (cfg_sel == 2'd2 && zero_cy))
        cfg_err <= 1'b1;
    end
  end

  logic          busy, we_q;
  logic [9:0]    cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [NB-1:0] be_q;
  logic [1:0]    wsync;

  logic [9:0] st_su, st_pw, cs_su, cs_pw, cyc;
  logic [9:0] st_end, cs_end, ctl_end, cap, last;
  logic       by_strb, wait_s, frozen_md, ready_md, stall, st_on, cs_on;

  assign st_su   = dec_su(we_q ? su_r[17:12] : su_r[5:0]);
  assign cs_su   = dec_su(we_q ? su_r[23:18] : su_r[11:6]);
  assign st_pw   = dec_pw(we_q ? pw_r[20:14] : pw_r[6:0]);
  assign cs_pw   = dec_pw(we_q ? pw_r[27:21] : pw_r[13:7]);
  assign cyc     = dec_cy(we_q ? cy_r[17:9]  : cy_r[8:0]);
  assign by_strb = we_q ? md_r[1] : md_r[0];

  assign st_end  = st_su + st_pw;
  assign cs_end  = cs_su + cs_pw;
  assign ctl_end = by_strb ? st_end : cs_end;
  assign cap     = (ctl_end < cyc) ? ctl_end - 10'd1 : cyc - 10'd1;
  assign last    = cyc - 10'd1;

  assign wait_s    = ~wsync[1];
  assign frozen_md = (md_r[3:2] == 2'b10);
  assign ready_md  = (md_r[3:2] == 2'b11);
  assign stall     = busy && wait_s && (frozen_md || (ready_md && cnt == cap));

  assign st_on = busy && (cnt >= st_su) && (cnt < st_end);
  assign cs_on = busy && (cnt >= cs_su) && (cnt < cs_end);

  assign cs_n     = ~cs_on;
  assign rd_n     = ~(st_on && !we_q);
  assign we_n     = ~({NB{st_on && we_q}} & be_q);
  assign mem_doe  = busy && we_q;
  assign mem_addr = addr_q;
  assign mem_dout = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wsync <= 2'b11;
    else        wsync <= {wsync[0], wait_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      we_q    <= 1'b0;
      cnt     <= 10'd0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      ack     <= 1'b0;
      rdata   <= '0;
    end else begin
      ack <= 1'b0;
      if (!busy && !ack && req) begin
        busy    <= 1'b1;
        cnt     <= 10'd0;
        we_q    <= req_we;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end else if (busy && !stall) begin
        if (cnt == cap && !we_q) rdata <= mem_din;
        if (cnt == last) begin
          busy <= 1'b0;
          ack  <= 1'b1;
        end else begin
          cnt <= cnt + 10'd1;
        end
      end
    end
  end

endmodule

// File: rtl/smc_cycle_engine_chk.sv
module smc_cycle_engine_chk #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          cs_n,
  input logic          rd_n,
  input logic [NB-1:0] we_n,
  input logic          mem_doe,
  input logic          cfg_err,
  input logic          busy,
  input logic          frozen_md,
  input logic          wait_s,
  input logic          wait_n
);

  AST_ACK_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R12

  AST_IDLE_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (cs_n && rd_n && (&we_n) && !mem_doe)); // R5

  AST_NO_READ_WRITE_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !(&we_n))); // R11

  AST_FROZEN_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frozen_md && wait_s) |=> $stable({cs_n, rd_n, we_n})); // R7

  AST_WAIT_TWO_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    wait_s |-> ($past(wait_n, 2) == 1'b0)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R4

endmodule

bind smc_cycle_engine smc_cycle_engine_chk #(.NB(NB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack       (ack),
  .cs_n      (cs_n),
  .rd_n      (rd_n),
  .we_n      (we_n),
  .mem_doe   (mem_doe),
  .cfg_err   (cfg_err),
  .busy      (busy),
  .frozen_md (frozen_md),
  .wait_s    (wait_s),
  .wait_n    (wait_n)
);

// File: tb/smc_cycle_engine_tb.sv
`timescale 1ns/1ps
module smc_cycle_engine_tb_top;
  localparam int AW = 23;
  localparam int DW = 16;
  localparam int NB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [27:0] cfg_wdata = '0;
  logic cfg_err;
  logic req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [NB-1:0] req_be = '0;
  logic ack;
  logic [DW-1:0] rdata, mem_dout, mem_din;
  logic [AW-1:0] mem_addr;
  logic mem_doe, cs_n, rd_n;
  logic [NB-1:0] we_n;
  logic wait_n = 1'b1;
  logic [31:0] tick = 32'd0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tick <= tick + 32'd1;
  assign mem_din = tick[15:0];

  smc_cycle_engine #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_doe(mem_doe), .mem_din(mem_din), .cs_n(cs_n), .rd_n(rd_n),
    .we_n(we_n), .wait_n(wait_n)
  );

  // raw fields: index 0 read strobe, 1 read cs, 2 write strobe, 3 write cs
  int su[4], pw[4], cy[2];
  bit rds, wrs;
  int wmd;

  function automatic int d_su(int r);
    return (r >= 32) ? 128 + (r - 32) : r;
  endfunction
  function automatic int d_pw(int r);
    int v = (r >= 64) ? 256 + (r - 64) : r;
    return (v == 0) ? 1 : v;
  endfunction
  function automatic int d_cy(int r);
    int v = (r / 128) * 256 + (r % 128);
    return (v == 0) ? 1 : v;
  endfunction
  function automatic int imin(int x, int y);
    return (x < y) ? x : y;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cfg_put(int sel, logic [27:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic apply_cfg();
    cfg_put(0, 28'(su[0] | (su[1] << 6) | (su[2] << 12) | (su[3] << 18)));
    cfg_put(1, 28'(pw[0] | (pw[1] << 7) | (pw[2] << 14) | (pw[3] << 21)));
    cfg_put(2, 28'(cy[0] | (cy[1] << 9)));
    cfg_put(3, 28'({2'(wmd), wrs, rds}));
  endtask

  // expected window: count and first index of a signal with setup s, pulse p
  task automatic win(int s, int p, int c, int sv, int e, output int cntv, output int first);
    int hi = imin(s + p, c);
    if (s >= hi) begin
      cntv = 0; first = -1;
    end else begin
      cntv = hi - s + ((sv >= s && sv < hi) ? e : 0);
      first = s + ((sv >= 0 && s > sv) ? e : 0);
    end
  endtask

  task automatic run_acc(string tag, bit we, logic [AW-1:0] ad, logic [DW-1:0] wd,
                         logic [NB-1:0] be, int a, int n);
    int csf = -1, csc = 0, rdf = -1, rdc = 0, ackk = -1, bad_d = 0, bad_a = 0;
    int wf[NB], wc[NB];
    logic [31:0] base = 32'd0;
    logic [DW-1:0] rv = '0;
    int s_st, p_st, s_cs, p_cs, c, ctl, cap, sv, e, ecsc, ecsf, estc, estf, cap_i;
    for (int i = 0; i < NB; i++) begin wf[i] = -1; wc[i] = 0; end
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = ad; req_wdata = wd; req_be = be;
    @(posedge clk);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      wait_n = !(a >= 0 && k >= a && k < a + n);
      if (k == 0) base = tick;
      if (!cs_n) begin if (csf < 0) csf = k; csc++; if (mem_addr !== ad) bad_a++; end
      if (!rd_n) begin if (rdf < 0) rdf = k; rdc++; end
      for (int i = 0; i < NB; i++)
        if (!we_n[i]) begin if (wf[i] < 0) wf[i] = k; wc[i]++; end
      if (!(&we_n) && (mem_dout !== wd || !mem_doe)) bad_d++;
      if (ack) begin ackk = k; rv = rdata; req = 1'b0; break; end
    end
    wait_n = 1'b1;
    @(negedge clk);
    chk("R12", "ack after completion", int'(ack), 0);

    s_st = d_su(we ? su[2] : su[0]); p_st = d_pw(we ? pw[2] : pw[0]);
    s_cs = d_su(we ? su[3] : su[1]); p_cs = d_pw(we ? pw[3] : pw[1]);
    c    = d_cy(we ? cy[1] : cy[0]);
    ctl  = (we ? wrs : rds) ? s_st + p_st : s_cs + p_cs;
    cap  = imin(ctl, c) - 1;
    sv = -1; e = 0;
    if (a >= 0 && wmd == 2 && a + 2 <= c - 1) begin sv = a + 2; e = n; end
    if (a >= 0 && wmd == 3 && a + 2 <= cap && a + n + 1 >= cap) begin
      sv = cap; e = a + n + 2 - cap;
    end
    win(s_cs, p_cs, c, sv, e, ecsc, ecsf);
    win(s_st, p_st, c, sv, e, estc, estf);
    cap_i = cap + ((sv >= 0 && cap >= sv) ? e : 0);

    chk(tag, "ack index", ackk, c + ((sv >= 0 && sv <= c - 1) ? e : 0));
    chk(tag, "cs_n low count", csc, ecsc);
    if (ecsc > 0) chk(tag, "cs_n first index", csf, ecsf);
    chk("R11", "address held", bad_a, 0);
    if (!we) begin
      chk(tag, "rd_n low count", rdc, estc);
      if (estc > 0) chk(tag, "rd_n first index", rdf, estf);
      chk("R11", "we_n during read", wc[0] + wc[1], 0);
      chk("R12", "read data", int'(rv), int'(16'(base + 32'(cap_i))));
    end else begin
      chk("R11", "rd_n during write", rdc, 0);
      chk("R11", "write data driven", bad_d, 0);
      for (int i = 0; i < NB; i++) begin
        chk(tag, "we_n low count", wc[i], be[i] ? estc : 0);
        if (be[i] && estc > 0) chk(tag, "we_n first index", wf[i], estf);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c1e));
    for (int i = 0; i < 4; i++) begin su[i] = 1; pw[i] = 1; end
    cy[0] = 3; cy[1] = 3; rds = 0; wrs = 0; wmd = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "cs_n in reset", int'(cs_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cs_n idle", int'(cs_n), 1);
    chk("R1", "rd_n idle", int'(rd_n), 1);
    chk("R1", "we_n idle", int'(we_n), 3);
    chk("R1", "ack idle", int'(ack), 0);
    chk("R1", "cfg_err idle", int'(cfg_err), 0);
    run_acc("R1", 1'b0, 23'h12345, 16'h0, 2'b11, -1, 0);
    run_acc("R1", 1'b1, 23'h00042, 16'hbeef, 2'b11, 0, 1);

    // long encodings
    su[0] = 34; pw[0] = 67; su[1] = 0; pw[1] = 64; cy[0] = 256; rds = 1;
    apply_cfg();
    run_acc("R2", 1'b0, 23'h7fff0, 16'h0, 2'b00, -1, 0);
    su[0] = 5; pw[0] = 1; cy[0] = 128 + 9;
    apply_cfg();
    run_acc("R3", 1'b0, 23'h1, 16'h0, 2'b00, -1, 0);

    // truncation by cycle length and control choice
    su[0] = 2; pw[0] = 5; su[1] = 0; pw[1] = 2; cy[0] = 4; rds = 1;
    apply_cfg();
    run_acc("R5", 1'b0, 23'h10, 16'h0, 2'b00, -1, 0);
    rds = 0;
    apply_cfg();
    run_acc("R10", 1'b0, 23'h11, 16'h0, 2'b00, -1, 0);

    // writes with byte enables
    su[2] = 1; pw[2] = 3; su[3] = 0; pw[3] = 6; cy[1] = 7; wrs = 1;
    apply_cfg();
    run_acc("R11", 1'b1, 23'h20, 16'ha55a, 2'b01, -1, 0);
    run_acc("R11", 1'b1, 23'h21, 16'h1234, 2'b10, -1, 0);
    run_acc("R11", 1'b1, 23'h22, 16'hffff, 2'b11, -1, 0);

    // frozen wait
    su[0] = 1; pw[0] = 4; su[1] = 0; pw[1] = 7; cy[0] = 10; rds = 1; wmd = 2;
    apply_cfg();
    run_acc("R6", 1'b0, 23'h30, 16'h0, 2'b00, 0, 1);
    run_acc("R7", 1'b0, 23'h31, 16'h0, 2'b00, 2, 3);
    run_acc("R7", 1'b1, 23'h32, 16'h5151, 2'b11, 4, 2);

    // ready wait: covers pulse end, and ends too early
    su[0] = 1; pw[0] = 3; cy[0] = 8; wmd = 3;
    apply_cfg();
    run_acc("R8", 1'b0, 23'h40, 16'h0, 2'b00, 1, 4);
    run_acc("R8", 1'b0, 23'h41, 16'h0, 2'b00, 0, 1);
    run_acc("R8", 1'b1, 23'h42, 16'h7777, 2'b11, 0, 5);

    // wait ignored when disabled or reserved
    wmd = 0;
    apply_cfg();
    run_acc("R9", 1'b0, 23'h50, 16'h0, 2'b00, 0, 5);
    wmd = 1;
    apply_cfg();
    run_acc("R9", 1'b0, 23'h51, 16'h0, 2'b00, 1, 4);

    // zero fields clamp and raise the sticky flag
    wmd = 0; apply_cfg();
    chk("R4", "cfg_err before zero write", int'(cfg_err), 0);
    for (int i = 0; i < 4; i++) pw[i] = 0;
    cfg_put(1, 28'd0);
    @(negedge clk);
    chk("R4", "cfg_err after zero pulse", int'(cfg_err), 1);
    run_acc("R4", 1'b0, 23'h60, 16'h0, 2'b00, -1, 0);
    cy[0] = 0;
    cfg_put(2, 28'(cy[1] << 9));
    run_acc("R4", 1'b0, 23'h61, 16'h0, 2'b00, -1, 0);
    for (int i = 0; i < 4; i++) pw[i] = 2;
    cy[0] = 6;
    apply_cfg();
    @(negedge clk);
    chk("R4", "cfg_err stays set", int'(cfg_err), 1);

    // random configurations and accesses
    for (int g = 0; g < 20; g++) begin
      for (int i = 0; i < 4; i++) begin
        su[i] = int'($urandom % 6);
        pw[i] = 1 + int'($urandom % 6);
      end
      cy[0] = 3 + int'($urandom % 22);
      cy[1] = 3 + int'($urandom % 22);
      rds = 1'($urandom); wrs = 1'($urandom);
      wmd = int'($urandom % 4);
      apply_cfg();
      for (int j = 0; j < 8; j++) begin
        bit we = 1'($urandom);
        int c = we ? cy[1] : cy[0];
        int n = 1 + int'($urandom % (c - 2));
        int a = int'($urandom % (c - 1 - n));
        if ($urandom % 3 == 0) a = -1;
        run_acc(wmd == 3 ? "R8" : (wmd == 2 ? "R7" : "R5"), we,
                AW'($urandom), DW'($urandom), NB'($urandom), a, n);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule